// File: doc/BRIEF.md
# Dual-Channel Down-Counting Timer

This block is a memory-mapped timer with two independent down-counting channels. Each channel holds a settings word and a start value. The settings word carries a run flag, an interrupt-enable flag, a two-bit mode selector and a prescale value P. While the run flag is set, the channel's counter steps down by one every P+1 clocks. When a step finds the counter already at zero, the channel has expired. In periodic mode it reloads its start value on that same step and carries on. In one-shot mode it clears its own run flag and stays at zero.

Each expiry sets a sticky bit in a shared event register. Software clears bits in that register by writing ones to them. A channel's interrupt line is high while its event bit is set and its interrupt-enable flag is on. The current count of the second channel can be read. Access is through a single-cycle 32-bit write strobe with a combinational read port, using word-aligned byte offsets.

Top module: `dual_cnt_timer`

## Requirements
- R1: After reset, every defined register reads zero and both interrupt lines are low.
- R2: The register map is as follows: channel 0 settings at 0x00, channel 1 settings at 0x04, channel 0 start value at 0x08, channel 1 start value at 0x0C, channel 1 live count at 0x14, event register at 0x18. In a settings word, bit 30 is run, bit 29 is interrupt enable, bits 28:27 are the mode (00 one-shot, 01 periodic), and bits 7:0 are the prescale P. All other settings bits read zero.
- R3: A read from any other offset, including a misaligned one, returns zero. A write to such an offset changes no register.
- R4: Writing a start value stores it (24 bits) and loads it into the counter at once. While run is set, the counter decrements once every P+1 clocks. The first decrement comes P+1 clocks after the run flag is written.
- R5: A step that finds the count at zero is an expiry. In periodic mode that same step reloads the start value, so expiries repeat every (start+1)·(P+1) clocks.
- R6: In one-shot mode, an expiry clears the channel's run bit, and the count then stays at zero.
- R7: Clearing run freezes the count. Setting run again resumes counting from the frozen value, with a fresh prescale period.
- R8: An expiry sets event bit n (bit 0 for channel 0, bit 1 for channel 1) whatever the interrupt-enable flag is. Interrupt line n is high exactly while event bit n and that channel's interrupt enable are both set.
- R9: Writing to the event register clears each bit written as 1 and leaves bits written as 0 unchanged. Writing 0x1F clears all of them.
- R10: If an expiry and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R11: The live-count register returns channel 1's counter in bits 23:0, with bits 31:24 zero. Start-value bits above 23 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 2 | Per-channel interrupt lines |

## Verification
Two things can act on the same event bit in one cycle: a hardware expiry setting it, and a software write-one clearing it. The bench works out the clock edge at which a one-shot channel expires. It then places a clearing write on exactly that edge. Reading the event register afterwards must show the bit still set, and a later clearing write must still remove it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int unsigned BUS_W         = 32;
   localparam int unsigned ADR_STRIDE    = 4;
   localparam int unsigned ADR_CTRL_BASE = 0;
   localparam int unsigned ADR_INIT_BASE = 8;
   localparam int unsigned ADR_LIVE1     = 20;
   localparam int unsigned ADR_EVENT     = 24;

   localparam int unsigned BIT_RUN       = 30;
   localparam int unsigned BIT_IEN       = 29;
   localparam int unsigned BIT_MODE_HI   = 28;
   localparam int unsigned BIT_MODE_LO   = 27;

   typedef enum logic [1:0] {
      MODE_ONESHOT  = 2'b00,
      MODE_PERIODIC = 2'b01
   } mode_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] div_sel,
   output logic             tick
);

   logic [PRE_W-1:0] pc_q;

   assign tick = run && (pc_q >= div_sel);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc_q <= '0;
      else if (!run || restart || tick)
         pc_q <= '0;
      else
         pc_q <= pc_q + 1'b1;
   end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   logic at_zero;

   assign at_zero = (cnt == '0);
   assign expire  = tick && at_zero && !load;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (tick) begin
         if (!at_zero)
            cnt <= cnt - 1'b1;
         else if (periodic)
            cnt <= reload_val;
      end
   end

endmodule

// File: rtl/tmr_events.sv
module tmr_events #(
   parameter int unsigned NCH  = 2,
   parameter int unsigned EV_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  set,
   input  logic            clr_we,
   input  logic [EV_W-1:0] clr_mask,
   output logic [EV_W-1:0] ev
);

   logic [EV_W-1:0] set_ext;
   logic [EV_W-1:0] keep;

   assign set_ext = EV_W'(set);
   assign keep    = clr_we ? ~clr_mask : '1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ev <= '0;
      else
         ev <= (ev & keep) | set_ext;
   end

endmodule

// File: rtl/dual_cnt_timer.sv
module dual_cnt_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned PRE_W  = 8,
   parameter int unsigned EV_W   = 5,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [1:0]        irq
);

   localparam int unsigned NCH = 2;

   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (PRE_W < 1 || PRE_W >= BIT_MODE_LO) begin : g_bad_pre
      $error("PRE_W overlaps mode field");
   end
   if (EV_W < NCH || EV_W > BUS_W) begin : g_bad_ev
      $error("EV_W out of range");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W too narrow for register map");
   end

   function automatic logic [ADDR_W-1:0] ctrl_adr(input int unsigned ch);
      return ADDR_W'(ADR_CTRL_BASE + ADR_STRIDE * ch);
   endfunction

   function automatic logic [ADDR_W-1:0] init_adr(input int unsigned ch);
      return ADDR_W'(ADR_INIT_BASE + ADR_STRIDE * ch);
   endfunction

   logic [NCH-1:0][BUS_W-1:0] ctrl_word;
   logic [NCH-1:0][CNT_W-1:0] init_word;
   logic [NCH-1:0][CNT_W-1:0] cnt_now;
   logic [NCH-1:0]            run_v;
   logic [NCH-1:0]            ien_v;
   logic [NCH-1:0]            tick_v;
   logic [NCH-1:0]            exp_v;
   logic [NCH-1:0]            load_v;
   logic [NCH-1:0]            per_v;
   logic [EV_W-1:0]           ev_q;
   logic                      ev_clr;
   logic                      unused_wd;

   assign unused_wd = ^bus_wdata;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic             wr_ctrl;
      logic             run_q;
      logic             ien_q;
      logic [1:0]       mode_q;
      logic [PRE_W-1:0] pre_q;
      logic [CNT_W-1:0] init_q;

      assign wr_ctrl   = bus_wr && (bus_addr == ctrl_adr(g));
      assign load_v[g] = bus_wr && (bus_addr == init_adr(g));
      assign per_v[g]  = (mode_q == MODE_PERIODIC);
      assign run_v[g]  = run_q;
      assign ien_v[g]  = ien_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            run_q  <= 1'b0;
            ien_q  <= 1'b0;
            mode_q <= MODE_ONESHOT;
            pre_q  <= '0;
         end else if (wr_ctrl) begin
            run_q  <= bus_wdata[BIT_RUN];
            ien_q  <= bus_wdata[BIT_IEN];
            mode_q <= bus_wdata[BIT_MODE_HI:BIT_MODE_LO];
            pre_q  <= bus_wdata[PRE_W-1:0];
         end else if (exp_v[g] && !per_v[g]) begin
            run_q  <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            init_q <= '0;
         else if (load_v[g])
            init_q <= bus_wdata[CNT_W-1:0];
      end

      always_comb begin
         ctrl_word[g]                          = '0;
         ctrl_word[g][BIT_RUN]                 = run_q;
         ctrl_word[g][BIT_IEN]                 = ien_q;
         ctrl_word[g][BIT_MODE_HI:BIT_MODE_LO] = mode_q;
         ctrl_word[g][PRE_W-1:0]               = pre_q;
      end

      assign init_word[g] = init_q;

      tmr_prescaler #(
         .PRE_W   (PRE_W)
      ) u_pre (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run_q),
         .restart (load_v[g]),
         .div_sel (pre_q),
         .tick    (tick_v[g])
      );

      tmr_counter #(
         .CNT_W      (CNT_W)
      ) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load_v[g]),
         .load_val   (bus_wdata[CNT_W-1:0]),
         .tick       (tick_v[g]),
         .periodic   (per_v[g]),
         .reload_val (init_q),
         .cnt        (cnt_now[g]),
         .expire     (exp_v[g])
      );
   end

   assign ev_clr = bus_wr && (bus_addr == ADDR_W'(ADR_EVENT));

   tmr_events #(
      .NCH      (NCH),
      .EV_W     (EV_W)
   ) u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (exp_v),
      .clr_we   (ev_clr),
      .clr_mask (bus_wdata[EV_W-1:0]),
      .ev       (ev_q)
   );

   assign irq = ev_q[NCH-1:0] & ien_v;

   always_comb begin
      bus_rdata = '0;
      for (int unsigned i = 0; i < NCH; i++) begin
         if (bus_addr == ctrl_adr(i)) bus_rdata = ctrl_word[i];
         if (bus_addr == init_adr(i)) bus_rdata = BUS_W'(init_word[i]);
      end
      if (bus_addr == ADDR_W'(ADR_LIVE1)) bus_rdata = BUS_W'(cnt_now[1]);
      if (bus_addr == ADDR_W'(ADR_EVENT)) bus_rdata = BUS_W'(ev_q);
   end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NCH    = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_wr,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [31:0]               bus_wdata,
   input logic [31:0]               bus_rdata,
   input logic [NCH-1:0]            irq,
   input logic [NCH-1:0]            run_v,
   input logic [NCH-1:0]            tick_v,
   input logic [NCH-1:0]            exp_v,
   input logic [NCH-1:0]            load_v,
   input logic [NCH-1:0]            per_v,
   input logic [NCH-1:0][CNT_W-1:0] cnt_now,
   input logic [NCH-1:0]            ev
);

   logic mapped;
   logic ev_wr;

   assign mapped = (bus_addr == ADDR_W'(0))  || (bus_addr == ADDR_W'(4))  ||
                   (bus_addr == ADDR_W'(8))  || (bus_addr == ADDR_W'(12)) ||
                   (bus_addr == ADDR_W'(ADR_LIVE1)) || (bus_addr == ADDR_W'(ADR_EVENT));
   assign ev_wr  = bus_wr && (bus_addr == ADDR_W'(ADR_EVENT));

   p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> bus_rdata == 32'h0);

   for (genvar g = 0; g < NCH; g++) begin : g_chk
      logic ctrl_wr;
      assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL_BASE + ADR_STRIDE * g));

      p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
         tick_v[g] && !load_v[g] && cnt_now[g] != '0 |=> cnt_now[g] == $past(cnt_now[g]) - 1'b1);

      p_periodic_keeps_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
         exp_v[g] && per_v[g] && !ctrl_wr |=> run_v[g]);

      p_oneshot_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
         exp_v[g] && !per_v[g] && !ctrl_wr |=> !run_v[g]);

      p_halt_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !run_v[g] && !load_v[g] |=> $stable(cnt_now[g]));

      p_irq_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
         irq[g] |-> ev[g]);

      p_event_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ev[g] && !(ev_wr && bus_wdata[g]) |=> ev[g]);

      p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
         exp_v[g] |=> ev[g]);
   end

endmodule

bind dual_cnt_timer tmr_checker #(
   .CNT_W     (CNT_W),
   .ADDR_W    (ADDR_W),
   .NCH       (2)
) u_tmr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .run_v     (run_v),
   .tick_v    (tick_v),
   .exp_v     (exp_v),
   .load_v    (load_v),
   .per_v     (per_v),
   .cnt_now   (cnt_now),
   .ev        (ev_q[1:0])
);

// File: tb/test_dual_cnt_timer.sv
module test_dual_cnt_timer;

   localparam logic [31:0] RUN = 32'h4000_0000;
   localparam logic [31:0] IEN = 32'h2000_0000;
   localparam logic [31:0] PER = 32'h0800_0000;

   localparam logic [7:0] A_C0 = 8'h00, A_C1 = 8'h04, A_I0 = 8'h08, A_I1 = 8'h0C;
   localparam logic [7:0] A_LV = 8'h14, A_EV = 8'h18;

   typedef struct {
      int    ch;
      longint cyc;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   int     n_chk = 0;
   int     n_fail = 0;
   longint cyc = 0;
   bit     done = 0;
   exp_item_t exp_q[$];

   dual_cnt_timer i_dual_cnt_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_to(input longint n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic expect_irq(input int ch, input longint at);
      exp_item_t it;
      it.ch  = ch;
      it.cyc = at;
      exp_q.push_back(it);
   endtask

   // scoreboard monitor: each irq rising edge must match the next expected expiry
   logic [1:0] irq_prev = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            if (irq[c] && !irq_prev[c]) begin
               if (exp_q.size() == 0) begin
                  n_chk++;
                  n_fail++;
                  $display("FAIL R8 unexpected irq ch%0d actual=cyc%0d expected=none", c, cyc);
               end else begin
                  exp_item_t it;
                  it = exp_q.pop_front();
                  check("R5 irq channel", 32'(c), 32'(it.ch));
                  check("R5 irq cycle", 32'(cyc), 32'(it.cyc));
               end
            end
         end
      end
      irq_prev <= irq;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      longint cw, ch, cr;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_C0, v); check("R1 ctrl0", v, 32'h0);
      rd(A_C1, v); check("R1 ctrl1", v, 32'h0);
      rd(A_I0, v); check("R1 init0", v, 32'h0);
      rd(A_I1, v); check("R1 init1", v, 32'h0);
      rd(A_LV, v); check("R1 live1", v, 32'h0);
      rd(A_EV, v); check("R1 events", v, 32'h0);
      check("R1 irq", {30'h0, irq}, 32'h0);

      // R2 field placement and readback
      wr(A_C1, IEN | PER | 32'h5);
      rd(A_C1, v); check("R2 ctrl1 readback", v, 32'h2800_0005);
      wr(A_C1, 32'hFFFF_FFFF);
      rd(A_C1, v); check("R2 ctrl1 reserved bits", v, 32'h7800_00FF);
      wr(A_C1, 32'h0);
      wr(A_I0, 32'h00AB_CDEF);
      rd(A_I0, v); check("R2 init0 readback", v, 32'h00AB_CDEF);
      wr(A_I1, 32'hFF12_3456);
      rd(A_I1, v); check("R11 init1 upper bits dropped", v, 32'h0012_3456);
      rd(A_LV, v); check("R4 R11 load on start write", v, 32'h0012_3456);

      // R3 unmapped and misaligned offsets
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h01, 32'hFFFF_FFFF);
      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h10, v); check("R3 read 0x10", v, 32'h0);
      rd(8'h01, v); check("R3 read 0x01", v, 32'h0);
      rd(A_C0, v);  check("R3 ctrl0 untouched", v, 32'h0);
      rd(A_I0, v);  check("R3 init0 untouched", v, 32'h00AB_CDEF);
      rd(A_EV, v);  check("R3 events untouched", v, 32'h0);

      // R5 R8 periodic channel 0 through the scoreboard: period (4+1)*(1+1)=10
      wr(A_I0, 32'd4);
      wr(A_C0, RUN | IEN | PER | 32'd1);
      cw = cyc;
      expect_irq(0, cw + 10);
      expect_irq(0, cw + 20);
      expect_irq(0, cw + 30);
      wait_to(cw + 12); wr(A_EV, 32'h1);
      wait_to(cw + 22); wr(A_EV, 32'h1);
      wait_to(cw + 32); wr(A_C0, 32'h0);
      wr(A_EV, 32'h1F);
      check("R9 irq low after clear", {30'h0, irq}, 32'h0);

      // R4 prescale 3 on channel 1, then R7 halt and resume
      wr(A_I1, 32'd50);
      wr(A_C1, RUN | 32'd3);
      cw = cyc;
      wait_to(cw + 9);  rd(A_LV, v); check("R4 two steps", v, 32'd48);
      wait_to(cw + 12); rd(A_LV, v); check("R4 three steps", v, 32'd47);
      wait_to(cw + 13); wr(A_C1, 32'd3);
      ch = cyc;
      wait_to(ch + 6);  rd(A_LV, v); check("R7 frozen", v, 32'd47);
      wr(A_C1, RUN | 32'd3);
      cr = cyc;
      wait_to(cr + 3);  rd(A_LV, v); check("R7 fresh prescale", v, 32'd47);
      wait_to(cr + 5);  rd(A_LV, v); check("R7 resumed", v, 32'd46);
      wr(A_C1, 32'h0);

      // R6 one-shot channel 1: steps at +1,+2, expiry at +3
      wr(A_I1, 32'd2);
      wr(A_C1, RUN | IEN);
      cw = cyc;
      expect_irq(1, cw + 3);
      wait_to(cw + 8);
      rd(A_C1, v); check("R6 run cleared", v, 32'h2000_0000);
      rd(A_LV, v); check("R6 count held at zero", v, 32'h0);
      rd(A_EV, v); check("R8 event bit1", v, 32'h2);
      check("R8 irq1 high", {30'h0, irq}, 32'h2);
      wr(A_EV, 32'h1);
      rd(A_EV, v); check("R9 zero-written bit kept", v, 32'h2);
      wr(A_EV, 32'h1F);
      rd(A_EV, v); check("R9 all cleared", v, 32'h0);

      // R8 event without interrupt enable
      wr(A_I0, 32'd1);
      wr(A_C0, RUN | PER);
      cw = cyc;
      wait_to(cw + 5);
      rd(A_EV, v); check("R8 event set without enable", v, 32'h1);
      check("R8 irq stays low", {30'h0, irq}, 32'h0);
      wr(A_C0, 32'h0);
      wr(A_EV, 32'h1F);

      // R10 clearing write lands on the expiry edge (cw+4)
      wr(A_I0, 32'd3);
      wr(A_C0, RUN);
      cw = cyc;
      wait_to(cw + 3); wr(A_EV, 32'h1);
      rd(A_EV, v); check("R10 set wins over clear", v, 32'h1);
      wr(A_EV, 32'h1);
      rd(A_EV, v); check("R10 later clear works", v, 32'h0);

      // R5 periodic reload visible on channel 1
      wr(A_I1, 32'd2);
      wr(A_C1, RUN | PER);
      cw = cyc;
      wait_to(cw + 2); rd(A_LV, v); check("R5 reached zero", v, 32'd0);
      wait_to(cw + 3); rd(A_LV, v); check("R5 reloaded", v, 32'd2);
      wait_to(cw + 4); rd(A_LV, v); check("R5 counting again", v, 32'd1);
      wr(A_C1, 32'h0);
      wr(A_EV, 32'h1F);

      repeat (3) @(negedge clk);
      check("R5 all expected expiries seen", 32'(exp_q.size()), 32'h0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule